// File: doc/BRIEF.md
# Prescaled Local Countdown Timer

This block is a single countdown timer for a local interrupt controller. A free-running prescaler divides the bus clock by a power of two chosen through a 4-bit configuration value. Each prescaler tick lowers the current count by one. When the count runs out, an expiry is recorded in a saturating pending counter. A timer vector entry holds three things: a mask bit, a periodic-mode bit and an 8-bit vector. In periodic mode the timer reloads and keeps running. In one-shot mode it stops after the first expiry.

Software reaches the block through a small word-addressed register port:

| Address | Register |
|---|---|
| 0 | Vector entry |
| 1 | Initial count |
| 2 | Current count (read-only) |
| 3 | Divide configuration |

Pending expiries are presented as an interrupt request that carries the vector. An acknowledge from the interrupt controller retires one pending expiry. The controller's software enable enters as a level input.

The countdown is an enumerated state machine with two states. `CT_IDLE` means stopped, and the current count is zero. `CT_RUN` means counting.

| Transition | From | To | Condition |
|---|---|---|---|
| LOAD_GO | `CT_IDLE` or `CT_RUN` | `CT_RUN` | A nonzero initial count is written |
| LOAD_STOP | any state | `CT_IDLE` | A zero initial count is written |
| TICK_DOWN | `CT_RUN` | `CT_RUN` | A tick arrives while the count is above one |
| RELOAD | `CT_RUN` | `CT_RUN` | A tick arrives at a count of one in periodic mode |
| FINISH | `CT_RUN` | `CT_IDLE` | A tick arrives at a count of one in one-shot mode |

Top module: `local_countdown_timer`

## Requirements
- R1: The divide configuration at address 3 keeps bits 3, 1 and 0; other bits read zero. The code {bit3, bit1, bit0} plus one, taken modulo 8, gives a shift s, and the divide ratio is 1<<s. Value 0xB therefore divides by 1, 0x0 by 2, 0x3 by 16, 0x8 by 32 and 0xA by 128.
- R2: Writing address 1 stores the initial count, which reads back at address 1. The write also restarts the prescaler, loads the current count and clears the pending counter.
- R3: After an initial count of zero is written, the timer stays stopped, the current count at address 2 reads 0 and no expiry occurs.
- R4: With divide ratio D and initial count N written at clock edge W, the current count falls by one every D edges. It reads N-k after edge W+k*D, and the expiry takes effect at edge W+N*D.
- R5: If bit 17 (periodic) of the vector entry is set, the count reloads from the initial count on expiry, so expiries repeat every N*D edges. If bit 17 is clear, the timer stops after one expiry with the current count at 0.
- R6: Each expiry adds one to the pending counter, which saturates at its maximum. The counter is visible on `pending_count`.
- R7: `irq_req` is high exactly when the pending counter is nonzero, mask bit 16 is clear and `sw_enable` is high. An `irq_ack` while `irq_req` is high lowers the pending counter by one.
- R8: While `sw_enable` is low, the mask bit is forced to 1 and the pending counter is held at 0.
- R9: A write to the vector entry keeps only bit 16 (mask), bit 17 (periodic) and bits 7:0 (vector); every other bit reads zero.
- R10: After reset the vector entry reads 0x10000 (masked), the initial count and divide configuration read 0, and the pending counter is 0.
- R11: A change of the divide configuration takes effect from the next prescaler tick. The remaining count is not restarted.
- R12: `irq_vector` always carries the vector field of the vector entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_enable | input | 1 | Software enable of the local interrupt controller |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_req | output | 1 | Timer interrupt request |
| irq_vector | output | 8 | Vector that goes with the request |
| irq_ack | input | 1 | Controller has accepted one pending timer interrupt |
| pending_count | output | 4 | Number of expiries not yet delivered |

## Verification
On every cycle the embedded assertions check the following:
- the stopped state always holds a zero count;
- a running count falls by exactly one per tick;
- a one-shot expiry ends in `CT_IDLE`;
- a load and a disable each empty the pending counter;
- an accepted acknowledge lowers the pending counter by one;
- a full pending counter saturates;
- the mask is set whenever the enable is low.

Only the bench scenarios can show the exact expiry cycle for each divide code, the periodic spacing of expiries, and the mid-count switch of the divide ratio with no restart. The bench measures these against cycle numbers it computes itself.

// File: rtl/lct_pkg.sv
package lct_pkg;

    // Width of the divide selector; the prescaler spans 2**SEL_W - 1 bits.
    localparam int SEL_W     = 3;
    localparam int PRE_W     = (1 << SEL_W) - 1;
    localparam int MASK_BIT  = 16;
    localparam int PERIOD_BIT = 17;

    typedef enum logic [1:0] {
        RA_VECTOR  = 2'd0,
        RA_INIT    = 2'd1,
        RA_CURRENT = 2'd2,
        RA_DIVIDE  = 2'd3
    } reg_addr_e;

    typedef enum logic {
        CT_IDLE = 1'b0,
        CT_RUN  = 1'b1
    } ct_state_e;

    // Divide selector: {cfg[3], cfg[1:0]} + 1, wrapping at 8.
    function automatic logic [SEL_W-1:0] div_shift(input logic [3:0] cfg);
        logic [SEL_W-1:0] code;
        code = {cfg[3], cfg[1:0]};
        return code + SEL_W'(1);
    endfunction

endpackage

// File: rtl/lct_prescaler.sv
module lct_prescaler
    import lct_pkg::*;
#(
    parameter int SHIFT_W = SEL_W,
    parameter int CNT_W   = PRE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] sel_mask;

    // One mask bit per prescaler stage: stage g takes part when shift > g.
    for (genvar gi = 0; gi < CNT_W; gi++) begin : g_mask
        assign sel_mask[gi] = (shift > SHIFT_W'(gi));
    end

    // Free-running; only an initial-count load restarts it, so a new
    // divide setting applies from the next matching tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign tick = ((cnt_q & sel_mask) == sel_mask);

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0)) else $error("prescaler not restarted"); // R2

endmodule

// File: rtl/lct_counter.sv
module lct_counter
    import lct_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             periodic,
    input  logic             tick,
    output logic [CNT_W-1:0] cur,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ct_state_e        st_q, st_d;
    logic [CNT_W-1:0] cur_q, cur_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= CT_IDLE;
            cur_q <= '0;
        end else begin
            st_q  <= st_d;
            cur_q <= cur_d;
        end
    end

    // Next state and outputs
    always_comb begin
        st_d   = st_q;
        cur_d  = cur_q;
        expire = 1'b0;
        if (load) begin
            // LOAD_GO / LOAD_STOP
            cur_d = load_val;
            st_d  = (load_val == '0) ? CT_IDLE : CT_RUN;
        end else begin
            unique case (st_q)
                CT_IDLE: begin
                    cur_d = '0;
                end
                CT_RUN: begin
                    if (tick) begin
                        if (cur_q == ONE) begin
                            expire = 1'b1;
                            if (periodic) begin
                                cur_d = reload_val;       // RELOAD
                                st_d  = (reload_val == '0) ? CT_IDLE : CT_RUN;
                            end else begin
                                cur_d = '0;               // FINISH
                                st_d  = CT_IDLE;
                            end
                        end else begin
                            cur_d = cur_q - ONE;          // TICK_DOWN
                        end
                    end
                end
                default: begin
                    st_d  = CT_IDLE;
                    cur_d = '0;
                end
            endcase
        end
    end

    assign cur = cur_q;

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CT_IDLE) |-> (cur_q == '0)) else $error("idle with count"); // R3

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CT_RUN && tick && cur_q > ONE && !load)
        |=> (cur_q == $past(cur_q) - ONE)) else $error("bad decrement"); // R4

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !periodic) |=> (st_q == CT_IDLE && cur_q == '0))
        else $error("one-shot kept running"); // R5

endmodule

// File: rtl/lct_deliver.sv
module lct_deliver #(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expire,
    input  logic              clear,
    input  logic              enable,
    input  logic              masked,
    input  logic              ack,
    output logic              req,
    output logic [PEND_W-1:0] pend
);

    localparam logic [PEND_W-1:0] PEND_MAX = '1;
    localparam logic [PEND_W-1:0] PEND_ONE = PEND_W'(1);

    logic [PEND_W-1:0] pend_q, pend_d;
    logic              inc, dec;

    assign req = enable && !masked && (pend_q != '0);
    assign inc = expire && (pend_q != PEND_MAX);
    assign dec = req && ack;

    always_comb begin
        pend_d = pend_q;
        if (!enable || clear) begin
            pend_d = '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   pend_d = pend_q + PEND_ONE;
                2'b01:   pend_d = pend_q - PEND_ONE;
                default: pend_d = pend_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend = pend_q;

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (pend_q == '0)) else $error("load kept pending"); // R2

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (pend_q == '0)) else $error("disabled with pending"); // R8

    AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack && !expire && !clear) |=> (pend_q == $past(pend_q) - PEND_ONE))
        else $error("ack did not retire"); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == PEND_MAX && expire && !ack && !clear && enable)
        |=> (pend_q == PEND_MAX)) else $error("pending wrapped"); // R6

endmodule

// File: rtl/local_countdown_timer.sv
module local_countdown_timer
    import lct_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int VEC_W  = 8,
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_enable,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vector,
    input  logic              irq_ack,
    output logic [PEND_W-1:0] pending_count
);

    reg_addr_e        addr;
    logic             vec_mask_q;
    logic             vec_period_q;
    logic [VEC_W-1:0] vec_num_q;
    logic [CNT_W-1:0] init_q;
    logic [3:0]       div_cfg_q;
    logic             load;
    logic             tick;
    logic             expire;
    logic [CNT_W-1:0] cur;

    assign addr = reg_addr_e'(reg_addr);
    assign load = reg_wr && (addr == RA_INIT);

    // Register file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_mask_q   <= 1'b1;
            vec_period_q <= 1'b0;
            vec_num_q    <= '0;
            init_q       <= '0;
            div_cfg_q    <= '0;
        end else begin
            if (reg_wr) begin
                unique case (addr)
                    RA_VECTOR: begin
                        vec_mask_q   <= reg_wdata[MASK_BIT] | !sw_enable;
                        vec_period_q <= reg_wdata[PERIOD_BIT];
                        vec_num_q    <= reg_wdata[VEC_W-1:0];
                    end
                    RA_INIT:    init_q    <= reg_wdata[CNT_W-1:0];
                    RA_DIVIDE:  div_cfg_q <= {reg_wdata[3], 1'b0, reg_wdata[1:0]};
                    RA_CURRENT: ;
                    default: ;
                endcase
            end
            if (!sw_enable) begin
                vec_mask_q <= 1'b1;
            end
        end
    end

    // Read mux
    always_comb begin
        reg_rdata = '0;
        unique case (addr)
            RA_VECTOR: begin
                reg_rdata[MASK_BIT]    = vec_mask_q;
                reg_rdata[PERIOD_BIT]  = vec_period_q;
                reg_rdata[VEC_W-1:0]   = vec_num_q;
            end
            RA_INIT:    reg_rdata = DATA_W'(init_q);
            RA_CURRENT: reg_rdata = DATA_W'(cur);
            RA_DIVIDE:  reg_rdata = DATA_W'(div_cfg_q);
            default:    reg_rdata = '0;
        endcase
    end

    lct_prescaler #(
        .SHIFT_W (SEL_W),
        .CNT_W   (PRE_W)
    ) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .shift   (div_shift(div_cfg_q)),
        .tick    (tick)
    );

    lct_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_val   (reg_wdata[CNT_W-1:0]),
        .reload_val (init_q),
        .periodic   (vec_period_q),
        .tick       (tick),
        .cur        (cur),
        .expire     (expire)
    );

    lct_deliver #(
        .PEND_W (PEND_W)
    ) u_deliver (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (expire),
        .clear  (load),
        .enable (sw_enable),
        .masked (vec_mask_q),
        .ack    (irq_ack),
        .req    (irq_req),
        .pend   (pending_count)
    );

    assign irq_vector = vec_num_q;

    AST_MASK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_enable |=> vec_mask_q) else $error("mask not forced"); // R8

    AST_REQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (!vec_mask_q && pending_count != '0)) else $error("req while masked"); // R7

endmodule

// File: tb/local_countdown_timer_bench.sv
module local_countdown_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_enable = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd2;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [7:0]  irq_vector;
    logic        irq_ack = 1'b0;
    logic [3:0]  pending_count;

    always #4 clk = ~clk;   // 125 MHz

    local_countdown_timer u_local_countdown_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_enable     (sw_enable),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .irq_req       (irq_req),
        .irq_vector    (irq_vector),
        .irq_ack       (irq_ack),
        .pending_count (pending_count)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    int    wr_cyc = 0;
    bit    done = 1'b0;
    bit    mon_on = 1'b1;
    int    exp_q[$];
    string tag_q[$];
    logic [3:0] prev_p = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Monitor: every rise of the pending counter is one expiry; pop and compare its cycle.
    always @(negedge clk) begin
        int    e;
        string t;
        if (mon_on && rst_n && pending_count > prev_p) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected expiry", 32'(cyc), 32'hFFFF_FFFF);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, 32'(cyc), 32'(e));
            end
        end
        prev_p = pending_count;
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd2;
        wr_cyc = cyc;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = 2'd2;
    endtask

    task automatic push(input int c, input string t);
        exp_q.push_back(c);
        tag_q.push_back(t);
    endtask

    task automatic drain(input int limit, input string t);
        for (int i = 0; i < limit && exp_q.size() != 0; i++) @(negedge clk);
        check(t, 32'(exp_q.size()), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        int          divs[5];
        logic [3:0]  cfgs[5];
        int          c;
        int          w;
        cfgs = '{4'hB, 4'h0, 4'h3, 4'h8, 4'hA};
        divs = '{1, 2, 16, 32, 128};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        rd(2'd0, d); check("R10 vector reset", d, 32'h0001_0000);
        rd(2'd1, d); check("R10 init reset", d, 32'h0);
        rd(2'd3, d); check("R10 divide reset", d, 32'h0);
        rd(2'd2, d); check("R10 current reset", d, 32'h0);
        check("R10 pending reset", 32'(pending_count), 32'h0);
        check("R10 no request", 32'(irq_req), 32'h0);

        // R9 field filtering, R12 vector output
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); check("R9 vector keeps fields", d, 32'h0003_00FF);
        wr(2'd0, 32'h0001_0000);
        rd(2'd0, d); check("R9 masked one-shot", d, 32'h0001_0000);

        // R1 divide readback keeps bits 3,1,0
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, d); check("R1 divide readback", d, 32'h0000_000B);

        // R1 each divide code, one-shot N=3
        for (int k = 0; k < 5; k++) begin
            wr(2'd3, 32'(cfgs[k]));
            wr(2'd1, 32'd3);
            push(wr_cyc + 3 * divs[k], $sformatf("R1 expiry with divide %0d", divs[k]));
            drain(3 * divs[k] + 10, "R1 expiry seen");
            check("R6 pending after one expiry", 32'(pending_count), 32'd1);
            rd(2'd2, d); check("R5 one-shot stopped at zero", d, 32'h0);
            check("R7 masked no request", 32'(irq_req), 32'h0);
        end

        // R4 countdown with divide 2, R2 init readback
        wr(2'd3, 32'h0);
        wr(2'd1, 32'd10);
        w = wr_cyc;
        check("R2 load clears pending", 32'(pending_count), 32'd0);
        rd(2'd1, d); check("R2 init readback", d, 32'd10);
        push(w + 20, "R4 expiry at N*D");
        repeat (6) @(negedge clk);
        rd(2'd2, d); check("R4 count after 3 ticks", d, 32'd7);
        @(negedge clk);
        rd(2'd2, d); check("R4 count between ticks", d, 32'd7);
        drain(40, "R4 expiry seen");

        // R11 divide change mid-count
        wr(2'd3, 32'h0);
        wr(2'd1, 32'd20);
        w = wr_cyc;
        repeat (3) @(negedge clk);
        wr(2'd3, 32'hB);
        c = wr_cyc;
        push(c + 20 - (c - w) / 2, "R11 divide change without restart");
        drain(60, "R11 expiry seen");

        // R5 periodic, divide 1, N=4
        wr(2'd3, 32'hB);
        wr(2'd0, 32'h0003_0000);
        wr(2'd1, 32'd4);
        w = wr_cyc;
        push(w + 4, "R5 periodic first");
        push(w + 8, "R5 periodic second");
        push(w + 12, "R5 periodic third");
        drain(30, "R5 periodic expiries seen");
        check("R6 pending counts three", 32'(pending_count), 32'd3);

        // R3 zero count stops
        wr(2'd1, 32'd0);
        repeat (30) @(negedge clk);
        rd(2'd2, d); check("R3 zero count reads zero", d, 32'h0);
        check("R3 no expiry when stopped", 32'(pending_count), 32'd0);

        // R6 saturation, periodic N=1 masked
        mon_on = 1'b0;
        wr(2'd1, 32'd1);
        repeat (30) @(negedge clk);
        check("R6 pending saturates", 32'(pending_count), 32'd15);
        check("R7 masked no request", 32'(irq_req), 32'h0);
        wr(2'd1, 32'd0);
        check("R2 load clears saturated pending", 32'(pending_count), 32'd0);
        mon_on = 1'b1;

        // R7 and R12 delivery
        wr(2'd0, 32'h0000_005A);
        wr(2'd1, 32'd2);
        push(wr_cyc + 2, "R7 delivery expiry");
        drain(10, "R7 expiry seen");
        check("R7 request raised", 32'(irq_req), 32'h1);
        check("R12 vector presented", 32'(irq_vector), 32'h5A);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check("R7 ack retires pending", 32'(pending_count), 32'd0);
        check("R7 request drops", 32'(irq_req), 32'h0);

        // R8 disable forces mask and clears pending
        wr(2'd1, 32'd2);
        push(wr_cyc + 2, "R8 expiry before disable");
        drain(10, "R8 expiry seen");
        check("R8 pending before disable", 32'(pending_count), 32'd1);
        sw_enable = 1'b0;
        @(negedge clk);
        check("R8 pending cleared", 32'(pending_count), 32'd0);
        check("R8 request low", 32'(irq_req), 32'h0);
        rd(2'd0, d); check("R8 mask forced", d, 32'h0001_005A);
        sw_enable = 1'b1;
        wr(2'd1, 32'd0);

        repeat (5) @(negedge clk);
        check("R6 no stray expiries", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        finish_run();
    end

endmodule